// File: doc/BRIEF.md
# Prioritized Interrupt Front-End

This block gathers every interrupt request aimed at a 16-bit stack processor and turns them into one request line toward the core. It takes five active-high level request lines, a group of internal timer request pulses, one active-high non-maskable input that reacts only to a rising edge, and a global suppress input. Every input is captured into a sampling register on the rising edge of the processor clock. A captured request is held as pending until the acknowledge cycle for that source. Masking and suppression decide which pending sources may compete. A fixed-priority encoder then picks a single winner.

Once a winner is chosen, a short sequencer raises the request line, holds a vector index for the core, and drives a one-cycle acknowledge strobe. The acknowledge cycle clears the served source and service begins on the next cycle. A non-maskable request that arrives while a maskable winner is still waiting for its acknowledge cycle takes that slot.

The mask register has one enable bit for each maskable source and is written through a plain write strobe. All pins are single-purpose control signals, so no valid/ready handshake is used and the request line is never held back by the core.

Top module: `irq_front`

## Requirements
- R1: After reset, `irq_req` and `irq_ack` are low, `irq_vec` is 0 and every mask bit is 0. A maskable request raised before any mask write is held pending and is served only after its mask bit is set.
- R2: A request captured at sampling edge E raises `irq_req` from edge E+1. `irq_ack` is high for exactly the single cycle between edges E+3 and E+4. Service begins at E+4, four cycles after the capture. `irq_ack` is never high without `irq_req`.
- R3: Vector codes: the non-maskable input is 0, timer request i is 1+i, and external line k (1..NUM_EXT) is 1+NUM_TMR+(NUM_EXT-k). With the defaults, line 5 is 4 and line 1 is 8.
- R4: When several sources are eligible together, the one with the lowest vector code wins. The others stay pending and are served one after another in code order.
- R5: Mask bit i enables timer i, and mask bit NUM_TMR+k-1 enables external line k. A masked source never raises `irq_req`. A value written with `mask_we` at edge W governs the decision made at edge W+1, so a newly enabled pending source raises `irq_req` after W+1 and not earlier.
- R6: While the sampled `irq_sup` is high, no maskable source can win, whatever its mask bit. The non-maskable source is still served. Maskable requests stay pending and are served after `irq_sup` falls.
- R7: The non-maskable input makes one service per rising edge. Holding it high does not produce a second service.
- R8: If a non-maskable request becomes eligible while a maskable winner has `irq_req` high but is not yet in its acknowledge cycle, `irq_vec` switches to 0 at the next edge. The acknowledge cycle then serves the non-maskable source, and the displaced source stays pending. Otherwise `irq_vec` is stable while `irq_req` is high.
- R9: A pending bit is cleared only by the acknowledge cycle of its own source. If a level line is still high when it is acknowledged, it re-arms at once: `irq_req` is low for exactly one cycle and then rises again with the same code.
- R10: A request that lasts a single clock cycle on any input is served exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock; all sampling happens on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq | input | 5 (NUM_EXT) | External request lines, bit k-1 is line k, active high |
| tmr_irq | input | 3 (NUM_TMR) | Internal timer request pulses, active high |
| nmi_irq | input | 1 | Non-maskable request, rising-edge sensitive |
| irq_sup | input | 1 | High blocks all maskable sources |
| mask_we | input | 1 | Write strobe for the mask register |
| mask_wdata | input | 8 (NUM_TMR+NUM_EXT) | New mask value, layout per R5 |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 4 | Vector code of the source being served (R3) |
| irq_ack | output | 1 | High during the acknowledge cycle |

## Verification
The hardest case to reach from the pins is the non-maskable takeover. The edge must land in the two-cycle window after a maskable winner has been latched and before its acknowledge cycle. The bench gets there by pulsing external line 1 and then raising the non-maskable input exactly one cycle after `irq_req` is seen high. It then checks that code 0 is acknowledged and that line 1 is still served afterwards. Re-arming is reached by holding a level line high through its acknowledge cycle and checking the one-cycle gap. The priority order is covered by a sweep over every pair of sources.

// File: rtl/irq_pkg.sv
package irq_pkg;

  // Sequencer phases for one delivered interrupt
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_REQ  = 2'd1,
    SEQ_HOLD = 2'd2,
    SEQ_ACK  = 2'd3
  } seq_state_e;

endpackage

// File: rtl/irq_sampler.sv
module irq_sampler #(
  parameter int NUM_TMR = 3,
  parameter int NUM_EXT = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] ext_in,
  input  logic [NUM_TMR-1:0] tmr_in,
  input  logic               nmi_in,
  input  logic               sup_in,
  output logic [NUM_EXT-1:0] ext_q,
  output logic [NUM_TMR-1:0] tmr_q,
  output logic               nmi_rise,
  output logic               sup_q
);

  logic nmi_q;
  logic nmi_d;

  // One capture register per input on the processor clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q <= '0;
      tmr_q <= '0;
      nmi_q <= 1'b0;
      nmi_d <= 1'b0;
      sup_q <= 1'b0;
    end else begin
      ext_q <= ext_in;
      tmr_q <= tmr_in;
      nmi_q <= nmi_in;
      nmi_d <= nmi_q;
      sup_q <= sup_in;
    end
  end

  // A low-to-high change between two captures is the only NMI event
  assign nmi_rise = nmi_q & ~nmi_d;

endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int NUM_SRC = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] pend_o
);

  // A set that coincides with a clear wins, which re-arms a held level line
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_o[s] <= 1'b0;
      else        pend_o[s] <= (pend_o[s] & ~clr_i[s]) | set_i[s];
    end
  end

endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int NUM_SRC = 9,
  parameter int VEC_W   = 4
) (
  input  logic [NUM_SRC-1:0] req_i,
  output logic               any_o,
  output logic [VEC_W-1:0]   idx_o
);

  // found[s] is high when some source with a code below s is requesting
  logic [NUM_SRC:0] found;
  logic [VEC_W-1:0] pick [NUM_SRC+1];

  assign found[0] = 1'b0;
  assign pick[0]  = '0;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_chain
    assign found[s+1] = found[s] | req_i[s];
    assign pick[s+1]  = (req_i[s] && !found[s]) ? VEC_W'(s) : pick[s];
  end

  assign any_o = found[NUM_SRC];
  assign idx_o = pick[NUM_SRC];

endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 9,
  parameter int VEC_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               any_req,
  input  logic [VEC_W-1:0]   win_idx,
  input  logic               nmi_ready,
  output logic               irq_o,
  output logic               ack_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic [NUM_SRC-1:0] clr_o
);

  seq_state_e       state;
  logic [VEC_W-1:0] vec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      vec_q <= '0;
    end else begin
      unique case (state)
        SEQ_IDLE: begin
          if (any_req) begin
            vec_q <= win_idx;
            state <= SEQ_REQ;
          end
        end
        SEQ_REQ: begin
          if (nmi_ready) vec_q <= '0;
          state <= SEQ_HOLD;
        end
        SEQ_HOLD: begin
          if (nmi_ready) vec_q <= '0;
          state <= SEQ_ACK;
        end
        SEQ_ACK: begin
          state <= SEQ_IDLE;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign irq_o = (state != SEQ_IDLE);
  assign ack_o = (state == SEQ_ACK);
  assign vec_o = vec_q;

  // Clear only the source that owns this acknowledge cycle
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_clr
    assign clr_o[s] = (state == SEQ_ACK) && (vec_q == VEC_W'(s));
  end

endmodule

// File: rtl/irq_front.sv
module irq_front #(
  parameter int NUM_TMR = 3,
  parameter int NUM_EXT = 5,
  localparam int NUM_SRC = 1 + NUM_TMR + NUM_EXT,
  localparam int NUM_MSK = NUM_TMR + NUM_EXT,
  localparam int VEC_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] ext_irq,
  input  logic [NUM_TMR-1:0] tmr_irq,
  input  logic               nmi_irq,
  input  logic               irq_sup,
  input  logic               mask_we,
  input  logic [NUM_MSK-1:0] mask_wdata,
  output logic               irq_req,
  output logic [VEC_W-1:0]   irq_vec,
  output logic               irq_ack
);

  logic [NUM_EXT-1:0] ext_q;
  logic [NUM_TMR-1:0] tmr_q;
  logic               nmi_rise;
  logic               sup_q;
  logic [NUM_MSK-1:0] mask_q;

  logic [NUM_SRC-1:0] src_set;
  logic [NUM_SRC-1:0] src_en;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] clr;
  logic [NUM_SRC-1:0] elig;
  logic               any_elig;
  logic [VEC_W-1:0]   win;

  irq_sampler #(.NUM_TMR(NUM_TMR), .NUM_EXT(NUM_EXT)) u_smp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_in   (ext_irq),
    .tmr_in   (tmr_irq),
    .nmi_in   (nmi_irq),
    .sup_in   (irq_sup),
    .ext_q    (ext_q),
    .tmr_q    (tmr_q),
    .nmi_rise (nmi_rise),
    .sup_q    (sup_q)
  );

  // Enable bits: timers low, then external lines in pin order
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_wdata;
  end

  // Place every source at its priority code; code 0 is never masked
  assign src_set[0] = nmi_rise;
  assign src_en[0]  = 1'b1;

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    assign src_set[1+t] = tmr_q[t];
    assign src_en[1+t]  = mask_q[t] & ~sup_q;
  end

  for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext
    assign src_set[1+NUM_TMR+e] = ext_q[NUM_EXT-1-e];
    assign src_en[1+NUM_TMR+e]  = mask_q[NUM_MSK-1-e] & ~sup_q;
  end

  irq_pending #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (src_set),
    .clr_i  (clr),
    .pend_o (pend)
  );

  // A fresh capture competes in the same cycle it lands
  assign elig = (pend | src_set) & src_en;

  irq_prio #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_prio (
    .req_i (elig),
    .any_o (any_elig),
    .idx_o (win)
  );

  irq_seq #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .any_req   (any_elig),
    .win_idx   (win),
    .nmi_ready (elig[0]),
    .irq_o     (irq_req),
    .ack_o     (irq_ack),
    .vec_o     (irq_vec),
    .clr_o     (clr)
  );

endmodule

// File: rtl/irq_front_chk.sv
module irq_front_chk #(
  parameter int VEC_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_sup,
  input logic             irq_req,
  input logic             irq_ack,
  input logic [VEC_W-1:0] irq_vec
);

  p_ack_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);

  p_ack_inside_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> irq_req);

  p_ack_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> ##2 irq_ack);

  p_vec_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && $past(irq_req) && !$stable(irq_vec)) |-> (irq_vec == '0));

  p_sup_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_req) && irq_vec != '0) |-> !$past(irq_sup, 2));

endmodule

bind irq_front irq_front_chk #(.VEC_W(VEC_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .irq_sup (irq_sup),
  .irq_req (irq_req),
  .irq_ack (irq_ack),
  .irq_vec (irq_vec)
);

// File: tb/tb_irq_front.sv
`timescale 1ns/1ps
module tb_irq_front;

  localparam int NT = 3;
  localparam int NE = 5;
  localparam int NS = 1 + NT + NE;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NE-1:0] ext = '0;
  logic [NT-1:0] tmr = '0;
  logic          nmi = 1'b0;
  logic          sup = 1'b0;
  logic          mwe = 1'b0;
  logic [7:0]    mdat = '0;
  logic          irq;
  logic [3:0]    vec;
  logic          ack;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  irq_front #(.NUM_TMR(NT), .NUM_EXT(NE)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_irq    (ext),
    .tmr_irq    (tmr),
    .nmi_irq    (nmi),
    .irq_sup    (sup),
    .mask_we    (mwe),
    .mask_wdata (mdat),
    .irq_req    (irq),
    .irq_vec    (vec),
    .irq_ack    (ack)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Code c -> pin: 0 NMI, 1..NT timers, then external lines from highest number
  task automatic set_src(input int c, input logic v);
    if (c == 0)       nmi = v;
    else if (c <= NT) tmr[c-1] = v;
    else              ext[NS-1-c] = v;
  endtask

  task automatic wr_mask(input logic [7:0] v);
    @(negedge clk); mwe = 1'b1; mdat = v;
    @(negedge clk); mwe = 1'b0;
  endtask

  task automatic quiet(input int cyc, input string req);
    int seen = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (irq) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  task automatic serve(input int exp_v, input string req);
    int n = 0;
    while (irq !== 1'b1 && n < 12) begin @(negedge clk); n++; end
    chk(irq === 1'b1, req, int'(irq), 1);
    chk(int'(vec) == exp_v, req, int'(vec), exp_v);
    n = 0;
    while (ack !== 1'b1 && n < 6) begin @(negedge clk); n++; end
    chk(ack === 1'b1 && int'(vec) == exp_v, req, int'(vec), exp_v);
    @(negedge clk);
    chk(ack === 1'b0, req, int'(ack), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(irq === 1'b0 && ack === 1'b0, "R1", int'(irq), 0);
    chk(vec === 4'd0, "R1", int'(vec), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq === 1'b0 && ack === 1'b0 && vec === 4'd0, "R1", int'(irq), 0);

    // R1: masks clear out of reset; pulse on line 5 is held
    @(negedge clk); ext[4] = 1'b1;
    @(negedge clk); ext[4] = 1'b0;
    quiet(6, "R1");

    // R5: line 3 masked; all other bits enabled still blocks it
    @(negedge clk); ext[2] = 1'b1;
    @(negedge clk); ext[2] = 1'b0;
    quiet(4, "R5");
    wr_mask(8'hDF);
    // with DF the pending line 5 (bit 7) is served first
    serve(4, "R1");
    quiet(5, "R5");
    // enable bit 5 (line 3): decision at W+1
    @(negedge clk); mwe = 1'b1; mdat = 8'h20;
    @(negedge clk); mwe = 1'b0;
    chk(irq === 1'b0, "R5", int'(irq), 0);
    @(negedge clk);
    chk(irq === 1'b1 && vec === 4'd6, "R5", int'(vec), 6);
    serve(6, "R5");
    wr_mask(8'hFF);

    // R2/R3/R10: every source alone, one-cycle pulse, exact timing
    for (int c = 0; c < NS; c++) begin
      @(negedge clk); set_src(c, 1'b1);
      @(negedge clk); set_src(c, 1'b0);
      chk(irq === 1'b0, "R2", int'(irq), 0);
      @(negedge clk);
      chk(irq === 1'b1, "R2", int'(irq), 1);
      chk(int'(vec) == c, "R3", int'(vec), c);
      @(negedge clk);
      chk(ack === 1'b0 && irq === 1'b1, "R2", int'(ack), 0);
      @(negedge clk);
      chk(ack === 1'b1 && int'(vec) == c, "R2", int'(vec), c);
      @(negedge clk);
      chk(ack === 1'b0 && irq === 1'b0, "R2", int'(irq), 0);
      quiet(3, "R10");
    end

    // R4: every pair of sources at once; lower code first
    for (int a = 0; a < NS; a++) begin
      for (int b = a + 1; b < NS; b++) begin
        @(negedge clk); set_src(a, 1'b1); set_src(b, 1'b1);
        @(negedge clk); set_src(a, 1'b0); set_src(b, 1'b0);
        serve((a < b) ? a : b, "R4");
        serve((a < b) ? b : a, "R4");
        quiet(2, "R4");
      end
    end

    // R6: suppress blocks line 2, NMI still served
    @(negedge clk); sup = 1'b1; ext[1] = 1'b1;
    quiet(8, "R6");
    @(negedge clk); nmi = 1'b1;
    @(negedge clk); nmi = 1'b0;
    serve(0, "R6");
    ext[1] = 1'b0;
    quiet(4, "R6");
    @(negedge clk); sup = 1'b0;
    serve(7, "R6");
    quiet(5, "R9");

    // R7: NMI held high gives a single service
    @(negedge clk); nmi = 1'b1;
    serve(0, "R7");
    quiet(8, "R7");
    nmi = 1'b0;
    quiet(2, "R7");

    // R8: NMI takes the slot of a latched line 1
    @(negedge clk); ext[0] = 1'b1;
    @(negedge clk); ext[0] = 1'b0;
    @(negedge clk);
    chk(irq === 1'b1 && vec === 4'd8, "R8", int'(vec), 8);
    nmi = 1'b1;
    @(negedge clk);
    chk(ack === 1'b0 && vec === 4'd8, "R8", int'(vec), 8);
    @(negedge clk);
    chk(ack === 1'b1 && vec === 4'd0, "R8", int'(vec), 0);
    nmi = 1'b0;
    @(negedge clk);
    serve(8, "R8");
    quiet(4, "R8");

    // R9: line 4 held through acknowledge re-arms after one idle cycle
    @(negedge clk); ext[3] = 1'b1;
    @(negedge clk);
    chk(irq === 1'b0, "R9", int'(irq), 0);
    @(negedge clk);
    chk(irq === 1'b1 && vec === 4'd5, "R9", int'(vec), 5);
    @(negedge clk);
    @(negedge clk);
    chk(ack === 1'b1, "R9", int'(ack), 1);
    @(negedge clk);
    chk(irq === 1'b0, "R9", int'(irq), 0);
    @(negedge clk);
    chk(irq === 1'b1 && vec === 4'd5, "R9", int'(vec), 5);
    ext[3] = 1'b0;
    serve(5, "R9");
    quiet(5, "R9");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule